// File: doc/BRIEF.md
# Speculative Line Buffer

This block sits between a last-level cache controller and its main-memory port. Cache lines brought in by speculative loads are kept in a staging store with one slot per core and per load-queue half-access. When the load later becomes safe, the controller sends an expose request. If the expose finds its own slot still holding the same line, the stored line is returned at once and memory is not read a second time.

Every request carries a core number, a load-queue slot (or a marker for "no slot"), a half-access bit and a kind: plain, speculative or expose. Plain reads and all exposes invalidate every buffered copy of their line in all cores. Plain reads, speculative reads and expose misses are forwarded to memory. A small tag queue travels alongside the outstanding reads, so that each memory response can be routed back upstream with its address and, for speculative reads, written into the right slot. Two saturating counters record expose hits and misses.

Top module: `spec_line_buffer`

## Requirements
- R1: After reset no slot holds a line, both counters read zero, and neither the expose-hit response nor the memory request is valid.
- R2: A plain read (kind 0) is forwarded to memory with its address unchanged. It invalidates every slot, in every core, that holds that address.
- R3: A speculative read (kind 1) is forwarded to memory and leaves the store unchanged at request time. When its memory response is accepted, the slot picked by its core and entry index takes the response's address and data.
- R4: An expose (kind 2) whose own slot (same core, same entry index) holds its address is a hit. No memory request is made. On the clock edge that accepts it, the hit counter increases by one, and the stored line and address appear on the hit response port one cycle after acceptance.
- R5: An expose hit invalidates every slot in every core that holds the exposed address, including the slot it read from.
- R6: An expose that is not a hit is a miss. The miss counter increases by one, every slot holding the address is invalidated, and the read is forwarded to memory.
- R7: The entry index is load slot × 2 plus the half bit (0 = first half, 1 = second half). A slot field of all ones (−1) means "no slot" and is legal only with kind 0. Kind code 3 is never used.
- R8: Hit detection looks only at the requester's own slot. A copy held under another core or another entry index never produces a hit.
- R9: Both counters saturate at their all-ones value and never decrease while out of reset.
- R10: A forwarded request is accepted only when memory is ready and the tag queue has room. An expose hit is accepted only when hitRspReady is high. A request that is not accepted makes no memory handshake and has no effect.
- R11: Memory responses pass upstream in request order. rspValid follows memRspValid, memRspReady follows rspReady, and rspAddr is the address of the oldest outstanding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high together with reqValid |
| reqKind | input | 2 | 0 plain, 1 speculative, 2 expose |
| reqCore | input | CORE_W | Requesting core |
| reqSlot | input | SLOT_W | Load-queue slot, two's complement, all ones = none |
| reqSecond | input | 1 | Second half of a split access |
| reqAddr | input | ADDR_W | Line address |
| hitRspReady | input | 1 | Hit response path can take a response next cycle |
| hitRspValid | output | 1 | Expose-hit response valid |
| hitRspAddr | output | ADDR_W | Address of the exposed line |
| hitRspData | output | LINE_W | Buffered line |
| memReqValid | output | 1 | Read request to memory |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | ADDR_W | Read address to memory |
| memRspValid | input | 1 | Memory read data valid |
| memRspReady | output | 1 | Read data taken |
| memRspData | input | LINE_W | Read data from memory |
| rspValid | output | 1 | Memory response forwarded upstream |
| rspReady | input | 1 | Upstream takes the response |
| rspAddr | output | ADDR_W | Address of the forwarded response |
| rspData | output | LINE_W | Data of the forwarded response |
| hitCount | output | CNT_W | Saturating expose-hit count |
| missCount | output | CNT_W | Saturating expose-miss count |

## Verification
The assertions assume well-formed requests: kind 3 is never presented, the no-slot marker comes only with kind 0, and memory never returns more responses than reads it has accepted. The bench builds every request with a legal kind and slot pairing. Its memory model answers only reads it has accepted, in order. It holds rspReady high, so the tag queue drains as the model answers. To probe backpressure, the bench asserts a request for less than a cycle and withdraws it before any clock edge can accept it.

// File: rtl/spec_line_pkg.sv
package spec_line_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_SPEC   = 2'd1,
    KIND_EXPOSE = 2'd2
  } reqKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clearMatch;   // invalidate every slot holding reqAddr
    logic captureHit;   // latch own slot into the hit response register
    logic fillWrite;    // write head-of-queue response into its slot
  } slbStrobe_t;

endpackage

// File: rtl/slb_ctrl.sv
module slb_ctrl
  import spec_line_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int LQ_SLOTS  = 33,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int TAG_DEPTH = 4,
  localparam int ENTRIES  = 2 * LQ_SLOTS,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int SLOT_W   = IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic              reqSecond,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [IDX_W-1:0]  reqIdx,
  input  logic              ownHit,
  input  logic              hitRspReady,
  output logic              memReqValid,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output logic              memRspReady,
  input  logic              rspReady,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [CORE_W-1:0] fillCore,
  output logic [IDX_W-1:0]  fillIdx,
  output logic [ADDR_W-1:0] fillAddr,
  output slbStrobe_t        strobe,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int PTR_W = (TAG_DEPTH > 1) ? $clog2(TAG_DEPTH) : 1;
  localparam int CNT_Q_W = $clog2(TAG_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(TAG_DEPTH - 1);
  localparam logic [CNT_Q_W-1:0] FULL_CNT = CNT_Q_W'(TAG_DEPTH);

  logic noSlot, isPlain, isSpec, isExpose, exposeHit;
  logic tagFull, accept, fwdAccept, hitAccept, push, pop;

  logic              tagFillQ [TAG_DEPTH];
  logic [CORE_W-1:0] tagCoreQ [TAG_DEPTH];
  logic [IDX_W-1:0]  tagIdxQ  [TAG_DEPTH];
  logic [ADDR_W-1:0] tagAddrQ [TAG_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_Q_W-1:0] tagCount;

  // request decode
  assign noSlot    = &reqSlot;
  assign reqIdx    = {reqSlot[IDX_W-2:0], reqSecond};
  assign isPlain   = (reqKind == KIND_PLAIN);
  assign isSpec    = (reqKind == KIND_SPEC);
  assign isExpose  = (reqKind == KIND_EXPOSE);
  assign exposeHit = isExpose && !noSlot && ownHit;

  // handshakes
  assign tagFull     = (tagCount == FULL_CNT);
  assign memReqValid = reqValid && !exposeHit && !tagFull;
  assign reqReady    = exposeHit ? hitRspReady : (memReqReady && !tagFull);
  assign accept      = reqValid && reqReady;
  assign fwdAccept   = accept && !exposeHit;
  assign hitAccept   = accept && exposeHit;

  assign push = fwdAccept;
  assign pop  = memRspValid && rspReady;

  assign memRspReady = rspReady;
  assign rspValid    = memRspValid;
  assign rspAddr     = tagAddrQ[rdPtr];
  assign fillCore    = tagCoreQ[rdPtr];
  assign fillIdx     = tagIdxQ[rdPtr];
  assign fillAddr    = tagAddrQ[rdPtr];

  always_comb begin
    strobe            = '0;
    strobe.clearMatch = accept && (isPlain || isExpose);
    strobe.captureHit = hitAccept;
    strobe.fillWrite  = pop && tagFillQ[rdPtr];
  end

  // tag queue payload
  always_ff @(posedge clk) begin
    if (push) begin
      tagFillQ[wrPtr] <= isSpec && !noSlot;
      tagCoreQ[wrPtr] <= reqCore;
      tagIdxQ[wrPtr]  <= reqIdx;
      tagAddrQ[wrPtr] <= reqAddr;
    end
  end

  // tag queue pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      tagCount <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   tagCount <= tagCount + 1'b1;
        2'b01:   tagCount <= tagCount - 1'b1;
        default: tagCount <= tagCount;
      endcase
    end
  end

  // saturating expose counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (hitAccept && !(&hitCount)) hitCount <= hitCount + 1'b1;
      if (fwdAccept && isExpose && !(&missCount)) missCount <= missCount + 1'b1;
    end
  end

  // R7
  legal_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqKind != 2'd3) && (!noSlot || isPlain));

  // R4
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitAccept |-> !memReqValid);

  // R10
  mem_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |-> (reqValid && reqReady));

  // R11
  rsp_has_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (tagCount != '0));

  // R9
  hit_cnt_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    ##1 hitCount >= $past(hitCount));

  // R9
  miss_cnt_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    ##1 missCount >= $past(missCount));

endmodule

// File: rtl/slb_datapath.sv
module slb_datapath
  import spec_line_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int LQ_SLOTS  = 33,
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 64,
  localparam int ENTRIES  = 2 * LQ_SLOTS,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int TOTAL    = NUM_CORES * ENTRIES
) (
  input  logic              clk,
  input  logic              rstN,
  input  slbStrobe_t        strobe,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              ownHit,
  input  logic [CORE_W-1:0] fillCore,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [LINE_W-1:0] fillData,
  output logic              hitRspValid,
  output logic [ADDR_W-1:0] hitRspAddr,
  output logic [LINE_W-1:0] hitRspData
);

  logic [ADDR_W-1:0] tagMem  [NUM_CORES][ENTRIES];
  logic [LINE_W-1:0] lineMem [NUM_CORES][ENTRIES];
  logic [ENTRIES-1:0] vld [NUM_CORES];

  logic [TOTAL-1:0] matchVec;  // slot holds reqAddr
  logic [TOTAL-1:0] fillVec;   // slot is target of this cycle's fill
  logic idxInRange;

  // CAM compare and fill decode for every slot
  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    for (genvar e = 0; e < ENTRIES; e++) begin : gEnt
      assign matchVec[c*ENTRIES+e] = vld[c][e] && (tagMem[c][e] == reqAddr);
      assign fillVec[c*ENTRIES+e]  = strobe.fillWrite &&
                                     (fillCore == CORE_W'(c)) &&
                                     (fillIdx == IDX_W'(e));
    end
  end

  assign idxInRange = (int'(reqIdx) < ENTRIES);
  assign ownHit     = idxInRange && vld[reqCore][reqIdx] &&
                      (tagMem[reqCore][reqIdx] == reqAddr);

  // valid bits: a fill to a slot wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CORES; c++) vld[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          if (fillVec[c*ENTRIES+e])
            vld[c][e] <= 1'b1;
          else if (strobe.clearMatch && matchVec[c*ENTRIES+e])
            vld[c][e] <= 1'b0;
        end
      end
    end
  end

  // line storage, written only by speculative fills
  always_ff @(posedge clk) begin
    if (strobe.fillWrite && (int'(fillIdx) < ENTRIES)) begin
      tagMem[fillCore][fillIdx]  <= fillAddr;
      lineMem[fillCore][fillIdx] <= fillData;
    end
  end

  // expose-hit response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitRspValid <= 1'b0;
      hitRspAddr  <= '0;
      hitRspData  <= '0;
    end else begin
      hitRspValid <= strobe.captureHit;
      if (strobe.captureHit) begin
        hitRspAddr <= reqAddr;
        hitRspData <= lineMem[reqCore][reqIdx];
      end
    end
  end

  // R5
  clear_after_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureHit && !fillVec[int'(reqCore)*ENTRIES + int'(reqIdx)])
      |=> !vld[$past(reqCore)][$past(reqIdx)]);

  // R4
  hit_from_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureHit |-> ownHit);

endmodule

// File: rtl/spec_line_buffer.sv
module spec_line_buffer
  import spec_line_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int LQ_SLOTS  = 33,
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 64,
  parameter int CNT_W     = 32,
  parameter int TAG_DEPTH = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W   = $clog2(2 * LQ_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic              reqSecond,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              hitRspReady,
  output logic              hitRspValid,
  output logic [ADDR_W-1:0] hitRspAddr,
  output logic [LINE_W-1:0] hitRspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  output logic              memRspReady,
  input  logic [LINE_W-1:0] memRspData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [LINE_W-1:0] rspData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int IDX_W = $clog2(2 * LQ_SLOTS);

  slbStrobe_t        strobe;
  logic [IDX_W-1:0]  reqIdx;
  logic              ownHit;
  logic [CORE_W-1:0] fillCore;
  logic [IDX_W-1:0]  fillIdx;
  logic [ADDR_W-1:0] fillAddr;

  assign memReqAddr = reqAddr;
  assign rspData    = memRspData;

  slb_ctrl #(
    .NUM_CORES(NUM_CORES), .LQ_SLOTS(LQ_SLOTS), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .TAG_DEPTH(TAG_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqCore(reqCore), .reqSlot(reqSlot), .reqSecond(reqSecond),
    .reqAddr(reqAddr), .reqIdx(reqIdx), .ownHit(ownHit),
    .hitRspReady(hitRspReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspReady(memRspReady),
    .rspReady(rspReady), .rspValid(rspValid), .rspAddr(rspAddr),
    .fillCore(fillCore), .fillIdx(fillIdx), .fillAddr(fillAddr),
    .strobe(strobe), .hitCount(hitCount), .missCount(missCount)
  );

  slb_datapath #(
    .NUM_CORES(NUM_CORES), .LQ_SLOTS(LQ_SLOTS), .ADDR_W(ADDR_W),
    .LINE_W(LINE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqCore(reqCore), .reqIdx(reqIdx), .reqAddr(reqAddr), .ownHit(ownHit),
    .fillCore(fillCore), .fillIdx(fillIdx), .fillAddr(fillAddr),
    .fillData(memRspData),
    .hitRspValid(hitRspValid), .hitRspAddr(hitRspAddr), .hitRspData(hitRspData)
  );

endmodule

// File: tb/spec_line_buffer_bench.sv
module spec_line_buffer_bench;

  localparam int CW = 3;
  localparam int SW = 7;
  localparam int CNTW = 3;
  localparam int SAT = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqSecond = 1'b0;
  logic [1:0] reqKind = '0;
  logic [CW-1:0] reqCore = '0;
  logic [SW-1:0] reqSlot = '0;
  logic [31:0] reqAddr = '0;
  logic reqReady;
  logic hitRspReady = 1'b1, hitRspValid;
  logic [31:0] hitRspAddr;
  logic [63:0] hitRspData;
  logic memReqValid, memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic memRspValid = 1'b0, memRspReady;
  logic [63:0] memRspData = '0;
  logic rspValid, rspReady = 1'b1;
  logic [31:0] rspAddr;
  logic [63:0] rspData;
  logic [CNTW-1:0] hitCount, missCount;

  int nChecks = 0, nFail = 0;
  int memGen = 1;
  logic memRspEn = 1'b1;
  logic [31:0] mq[$];
  logic [95:0] rspLog[$];
  int expHit = 0, expMiss = 0;

  always #5 clk = ~clk;

  spec_line_buffer #(.CNT_W(CNTW), .TAG_DEPTH(4)) u_spec_line_buffer (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqCore(reqCore), .reqSlot(reqSlot), .reqSecond(reqSecond),
    .reqAddr(reqAddr), .hitRspReady(hitRspReady), .hitRspValid(hitRspValid),
    .hitRspAddr(hitRspAddr), .hitRspData(hitRspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspReady(memRspReady), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspAddr(rspAddr), .rspData(rspData),
    .hitCount(hitCount), .missCount(missCount)
  );

  // memory model: in-order, data tagged with current generation
  always @(posedge clk) begin
    if (rstN && memReqValid && memReqReady) mq.push_back(memReqAddr);
    if (rstN && memRspValid && memRspReady) void'(mq.pop_front());
    if (rstN && rspValid && rspReady) rspLog.push_back({rspAddr, rspData});
  end

  always @(negedge clk) begin
    memRspValid = memRspEn && (mq.size() != 0);
    memRspData  = (mq.size() != 0) ? {mq[0], 32'(memGen)} : 64'd0;
  end

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  task automatic doReq(input logic [1:0] k, input int core, input int slot,
                       input logic sec, input logic [31:0] a,
                       output logic wentMem, output logic hitSeen,
                       output logic [95:0] hitLine);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqCore = CW'(core);
    reqSlot = SW'(slot); reqSecond = sec; reqAddr = a;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    wentMem = memReqValid;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    hitSeen = hitRspValid;
    hitLine = {hitRspAddr, hitRspData};
  endtask

  task automatic drain();
    while (mq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic specFill(input int core, input int slot, input logic sec,
                          input logic [31:0] a);
    logic m, h; logic [95:0] d;
    doReq(2'd1, core, slot, sec, a, m, h, d);
    drain();
  endtask

  task automatic plainRead(input logic [31:0] a);
    logic m, h; logic [95:0] d;
    doReq(2'd0, 0, -1, 1'b0, a, m, h, d);
    check("R2 plain read forwarded", {95'd0, m}, 96'd1);
    drain();
  endtask

  // expose with expected outcome; expData only used for a hit
  task automatic expose(input string req, input int core, input int slot,
                        input logic sec, input logic [31:0] a,
                        input logic expHitRes, input logic [31:0] gen);
    logic m, h; logic [95:0] d;
    doReq(2'd2, core, slot, sec, a, m, h, d);
    if (expHitRes) expHit++; else expMiss++;
    check({req, " memory issued"}, {95'd0, m}, {95'd0, !expHitRes});
    check({req, " hit response"}, {95'd0, h}, {95'd0, expHitRes});
    if (expHitRes) check({req, " hit line"}, d, {a, a, gen});
    check({req, " hit count"}, 96'(hitCount), 96'(sat(expHit)));
    check({req, " miss count"}, 96'(missCount), 96'(sat(expMiss)));
    drain();
  endtask

  task automatic tReset();
    check("R1 hit count zero", 96'(hitCount), 96'd0);
    check("R1 miss count zero", 96'(missCount), 96'd0);
    check("R1 no hit response", {95'd0, hitRspValid}, 96'd0);
    check("R1 no mem request", {95'd0, memReqValid}, 96'd0);
    expose("R1 empty store", 0, 0, 1'b0, 32'h0, 1'b0, 0);
  endtask

  task automatic tSpecHit();
    int g;
    g = memGen;
    specFill(2, 5, 1'b0, 32'h1000);
    check("R11 fill passed upstream", rspLog[rspLog.size()-1], {32'h1000, 32'h1000, 32'(g)});
    memGen++;
    // R3 R4: stale generation proves data came from the store
    expose("R4 own-slot hit", 2, 5, 1'b0, 32'h1000, 1'b1, 32'(g));
  endtask

  task automatic tHitClears();
    int g;
    g = memGen;
    specFill(1, 3, 1'b0, 32'h2000);
    specFill(4, 3, 1'b0, 32'h2000);
    memGen++;
    expose("R5 first copy hits", 1, 3, 1'b0, 32'h2000, 1'b1, 32'(g));
    expose("R5 other core copy cleared", 4, 3, 1'b0, 32'h2000, 1'b0, 0);
    expose("R5 used slot cleared", 1, 3, 1'b0, 32'h2000, 1'b0, 0);
  endtask

  task automatic tPlainClears();
    specFill(0, 0, 1'b0, 32'h3000);
    specFill(5, 2, 1'b1, 32'h3000);
    memGen++;
    plainRead(32'h3000);
    expose("R2 core0 copy cleared", 0, 0, 1'b0, 32'h3000, 1'b0, 0);
    expose("R2 core5 copy cleared", 5, 2, 1'b1, 32'h3000, 1'b0, 0);
  endtask

  task automatic tMissClears();
    specFill(3, 7, 1'b0, 32'h4000);
    specFill(5, 7, 1'b0, 32'h4000);
    expose("R6 miss other index", 5, 6, 1'b0, 32'h4000, 1'b0, 0);
    expose("R6 miss cleared core3", 3, 7, 1'b0, 32'h4000, 1'b0, 0);
  endtask

  task automatic tIndexing();
    int g;
    specFill(6, 9, 1'b0, 32'h5000);
    expose("R7 second half misses first-half fill", 6, 9, 1'b1, 32'h5000, 1'b0, 0);
    g = memGen;
    specFill(6, 9, 1'b1, 32'h5040);
    specFill(6, 10, 1'b0, 32'h5080);
    memGen++;
    expose("R7 second half hits", 6, 9, 1'b1, 32'h5040, 1'b1, 32'(g));
    expose("R8 address mismatch misses", 6, 10, 1'b0, 32'h50C0, 1'b0, 0);
    specFill(7, 1, 1'b0, 32'h6000);
    expose("R8 other core misses", 0, 1, 1'b0, 32'h6000, 1'b0, 0);
  endtask

  task automatic tBackpressure();
    int g;
    logic m, h; logic [95:0] d;
    // memory not ready
    memReqReady = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd0; reqCore = '0; reqSlot = '1; reqAddr = 32'h7000;
    #1;
    check("R10 stalled by memory", {95'd0, reqReady}, 96'd0);
    check("R10 mem request offered", {95'd0, memReqValid}, 96'd1);
    reqValid = 1'b0;
    memReqReady = 1'b1;
    // hit path not ready
    g = memGen;
    specFill(2, 4, 1'b0, 32'h7100);
    memGen++;
    hitRspReady = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd2; reqCore = 3'd2; reqSlot = 7'd4;
    reqSecond = 1'b0; reqAddr = 32'h7100;
    #1;
    check("R10 hit stalled", {95'd0, reqReady}, 96'd0);
    check("R10 stalled hit not to memory", {95'd0, memReqValid}, 96'd0);
    reqValid = 1'b0;
    hitRspReady = 1'b1;
    expose("R10 stalled hit had no effect", 2, 4, 1'b0, 32'h7100, 1'b1, 32'(g));
    // tag queue full
    memRspEn = 1'b0;
    for (int i = 0; i < 4; i++) doReq(2'd0, 0, -1, 1'b0, 32'h7200 + 32'(i), m, h, d);
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd0; reqSlot = '1; reqAddr = 32'h7300;
    #1;
    check("R10 stalled by full tag queue", {95'd0, reqReady}, 96'd0);
    reqValid = 1'b0;
    memRspEn = 1'b1;
    drain();
    check("R11 in-order addr 0", {64'd0, rspLog[rspLog.size()-4][95:64]}, 96'h7200);
    check("R11 in-order addr 3", {64'd0, rspLog[rspLog.size()-1][95:64]}, 96'h7203);
  endtask

  task automatic tSaturate();
    int g;
    for (int i = 0; i < 6; i++) begin
      g = memGen;
      specFill(i, 20, 1'b0, 32'h8000 + 32'(i*64));
      expose("R9 hit saturation", i, 20, 1'b0, 32'h8000 + 32'(i*64), 1'b1, 32'(g));
    end
    for (int i = 0; i < 4; i++)
      expose("R9 miss saturation", 1, 30, 1'b1, 32'h9000, 1'b0, 0);
    check("R9 hit count pinned", 96'(hitCount), 96'(SAT));
    check("R9 miss count pinned", 96'(missCount), 96'(SAT));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSpecHit();
    tHitClears();
    tPlainClears();
    tMissClears();
    tIndexing();
    tBackpressure();
    tSaturate();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule